// File: doc/BRIEF.md
# Descriptor Immediate Word Load/Store Engine

This block carries out the two descriptor commands that move one small quantity, one, two or four bytes wide, between system memory and the descriptor's 32-bit dependent word. The channel sequencer hands it a decoded command: the direction, the three-bit address-space key, the low three bits of the request count, the memory address and the current dependent word. The engine checks the key, works out the access size and alignment, issues one memory beat and returns the updated dependent word. It then pulses either a completion or a kill indication.

The engine does not decide on waits or interrupts and does not advance the descriptor pointer. On a completion pulse the sequencer clears its flush flag, evaluates the conditional interrupt and moves to the next descriptor without branching. On a kill pulse it marks the channel dead. The memory side is a single-beat request port with a byte count. The request is held steady until the memory raises its acknowledge.

The engine is a four-state machine. **IDLE** waits for `start`. The *launch* transition goes to **ACCESS** when the key is accepted. The *reject* transition goes to **ABORT** when the key is refused. **ACCESS** drives the memory request, and its *complete* transition goes to **FINISH** on `mem_ack`. **FINISH** pulses `done` and **ABORT** pulses `kill`. Both leave through the *retire* transition back to IDLE.

Top module: `imm_ldst_engine`

## Requirements
- R1: The access size comes from `req_cnt[2:0]` by priority. Bit 2 set gives 4 bytes. Otherwise bit 1 set gives 2 bytes. Otherwise the size is 1 byte. `mem_size` carries the byte count as the value 4, 2 or 1.
- R2: For a 4-byte access, `mem_addr` is `addr` with bits 1:0 cleared. For a 2-byte access, bit 0 is cleared. For a 1-byte access, `addr` passes through unchanged.
- R3: A load (`store`=0) takes its read data from the low bytes of `mem_rdata`. A 4-byte load returns `mem_rdata` whole. A 2-byte load returns `{mem_rdata[15:0], dep_in[15:0]}`. A 1-byte load returns `{mem_rdata[7:0], dep_in[23:0]}`.
- R4: A store (`store`=1) drives `mem_we`=1. `mem_wdata` is `dep_in` for 4 bytes, `dep_in>>16` for 2 bytes and `dep_in>>24` for 1 byte, with the upper bits zero. `dep_out` after a store equals `dep_in`.
- R5: Keys 0 to 3 and key 6 (system memory) are accepted and perform the access. Keys 4, 5 and 7 are refused. A refused key pulses `kill` one cycle after `start`, issues no memory request and leaves `dep_out` equal to `dep_in`.
- R6: From the cycle after an accepted `start`, `mem_req` stays high with address, size, direction and write data unchanged until the cycle in which `mem_ack` is high.
- R7: `done` is high for exactly the one cycle that follows the acknowledged cycle, and `dep_out` holds the result in that cycle.
- R8: `start` has no effect while the engine is busy: the access in progress keeps its address and data, and it completes once.
- R9: After reset the engine is idle, with `busy`, `done`, `kill` and `mem_req` low. `done`, `kill` and `mem_req` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a command (sampled in IDLE) |
| store | input | 1 | 1 = store dependent word, 0 = load into it |
| key | input | 3 | Address-space key of the command |
| req_cnt | input | 3 | Low three bits of the descriptor request count |
| addr | input | ADDR_W | Memory address from the descriptor |
| dep_in | input | 32 | Current dependent word |
| busy | output | 1 | Engine not idle |
| done | output | 1 | One-cycle completion pulse |
| kill | output | 1 | One-cycle refused-key pulse |
| dep_out | output | 32 | Updated dependent word |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | ADDR_W | Aligned memory address |
| mem_size | output | 3 | Byte count: 1, 2 or 4 |
| mem_wdata | output | 32 | Store data, right-justified |
| mem_rdata | input | 32 | Load data, right-justified |
| mem_ack | input | 1 | Memory acknowledge |

## Verification
Both directions are swept against all eight request-count codes and all four low address offsets. This separates the priority decode from a plain binary reading and exposes any alignment mask applied at the wrong size. Acknowledge delays of zero, one and two cycles show whether the request holds steady while it waits. Every key value is issued to tell accepted keys from refused ones. A second `start` pulse during a stalled access shows whether the engine ignores it.

// File: rtl/imm_ldst_pkg.sv
package imm_ldst_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACCESS = 2'd1,
        ST_FINISH = 2'd2,
        ST_ABORT  = 2'd3
    } ldst_state_e;

    localparam logic [2:0] KEY_RESERVED = 3'd4;
    localparam logic [2:0] KEY_REGSPACE = 3'd5;
    localparam logic [2:0] KEY_SYSMEM   = 3'd6;
    localparam int         WORD_W       = 32;
endpackage

// File: rtl/imm_size_decode.sv
module imm_size_decode #(
    parameter int ADDR_W = 32
) (
    input  logic [2:0]        cnt_bits,
    input  logic [ADDR_W-1:0] raw_addr,
    output logic [2:0]        byte_cnt,
    output logic [ADDR_W-1:0] aligned_addr
);
    // Priority: 4 bytes over 2 bytes over 1 byte; mask the address to match.
    always_comb begin
        aligned_addr = raw_addr;
        if (cnt_bits[2]) begin
            byte_cnt          = 3'd4;
            aligned_addr[1:0] = 2'b00;
        end else if (cnt_bits[1]) begin
            byte_cnt        = 3'd2;
            aligned_addr[0] = 1'b0;
        end else begin
            byte_cnt = 3'd1;
        end
    end
endmodule

// File: rtl/imm_word_merge.sv
module imm_word_merge
    import imm_ldst_pkg::*;
(
    input  logic [2:0]        byte_cnt,
    input  logic [WORD_W-1:0] dep_word,
    input  logic [WORD_W-1:0] rd_data,
    output logic [WORD_W-1:0] load_word,
    output logic [WORD_W-1:0] store_data
);
    // Narrow loads land in the top bytes; narrow stores send the top bytes.
    always_comb begin
        unique case (byte_cnt)
            3'd4: begin
                load_word  = rd_data;
                store_data = dep_word;
            end
            3'd2: begin
                load_word  = {rd_data[15:0], dep_word[15:0]};
                store_data = {16'h0000, dep_word[31:16]};
            end
            default: begin
                load_word  = {rd_data[7:0], dep_word[23:0]};
                store_data = {24'h000000, dep_word[31:24]};
            end
        endcase
    end
endmodule

// File: rtl/imm_ldst_engine.sv
module imm_ldst_engine
    import imm_ldst_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              store,
    input  logic [2:0]        key,
    input  logic [2:0]        req_cnt,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       dep_in,
    output logic              busy,
    output logic              done,
    output logic              kill,
    output logic [31:0]       dep_out,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [2:0]        mem_size,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    input  logic              mem_ack
);
    ldst_state_e state_q, state_d;

    logic [2:0]        dec_cnt;
    logic [ADDR_W-1:0] dec_addr;
    logic [31:0]       merged_load, shifted_store;
    logic [31:0]       dep_q;
    logic [2:0]        size_q;
    logic [ADDR_W-1:0] addr_q;
    logic              we_q;
    logic              key_ok;

    imm_size_decode #(.ADDR_W(ADDR_W)) u_size (
        .cnt_bits     (req_cnt),
        .raw_addr     (addr),
        .byte_cnt     (dec_cnt),
        .aligned_addr (dec_addr)
    );

    imm_word_merge u_merge (
        .byte_cnt   (size_q),
        .dep_word   (dep_q),
        .rd_data    (mem_rdata),
        .load_word  (merged_load),
        .store_data (shifted_store)
    );

    // Low stream keys fold onto system memory; reserved, register and device keys are refused.
    assign key_ok = (key < KEY_RESERVED) || (key == KEY_SYSMEM);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = key_ok ? ST_ACCESS : ST_ABORT;
            ST_ACCESS: if (mem_ack) state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            ST_ABORT:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            dep_q   <= '0;
            size_q  <= 3'd1;
            addr_q  <= '0;
            we_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && start) begin
                dep_q  <= dep_in;
                size_q <= dec_cnt;
                addr_q <= dec_addr;
                we_q   <= store;
            end else if (state_q == ST_ACCESS && mem_ack && !we_q) begin
                dep_q <= merged_load;
            end
        end
    end

    always_comb begin
        busy      = (state_q != ST_IDLE);
        done      = (state_q == ST_FINISH);
        kill      = (state_q == ST_ABORT);
        mem_req   = (state_q == ST_ACCESS);
        mem_we    = mem_req && we_q;
        mem_addr  = addr_q;
        mem_size  = size_q;
        mem_wdata = we_q ? shifted_store : 32'h0;
        dep_out   = dep_q;
    end

    // R6
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_size)
                                && $stable(mem_we) && $stable(mem_wdata));
    // R2
    align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_size != 3'd4 || mem_addr[1:0] == 2'b00)
                 && (mem_size != 3'd2 || mem_addr[0] == 1'b0));
    // R1
    size_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> $countones(mem_size) == 1 && mem_size != 3'd0);
    // R9
    excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, kill, mem_req}));
    // R7
    done_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_ack |=> done ##1 !done);
    // R5
    kill_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        kill |=> !kill && !mem_req);
endmodule

// File: tb/imm_ldst_engine_bench.sv
module imm_ldst_engine_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        start, store, mem_ack;
    logic [2:0]  key, req_cnt;
    logic [31:0] addr, dep_in, mem_rdata;
    logic        busy, done, kill, mem_req, mem_we;
    logic [31:0] dep_out, mem_addr, mem_wdata;
    logic [2:0]  mem_size;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    imm_ldst_engine #(.ADDR_W(32)) u_imm_ldst_engine (
        .clk(clk), .rst_n(rst_n), .start(start), .store(store), .key(key),
        .req_cnt(req_cnt), .addr(addr), .dep_in(dep_in), .busy(busy),
        .done(done), .kill(kill), .dep_out(dep_out), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    function automatic logic [31:0] rd_model(input logic [31:0] a);
        return {a[15:0] ^ 16'h5A3C, a[15:0] + 16'h1357};
    endfunction

    assign mem_rdata = rd_model(mem_addr);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 50000);
            finish_run();
        end
    end

    // Run one command; extra_start pulses start while the access waits (R8).
    task automatic run_op(input logic st, input logic [2:0] k, input logic [2:0] rc,
                          input logic [31:0] a, input logic [31:0] d, input int dly,
                          input logic extra_start);
        logic [2:0]  sz;
        logic [31:0] aa, exp_w, exp_dep, rd;
        logic        ok;
        sz = rc[2] ? 3'd4 : (rc[1] ? 3'd2 : 3'd1);
        aa = a;
        if (sz == 3'd4) aa[1:0] = 2'b00;
        if (sz == 3'd2) aa[0] = 1'b0;
        ok = (k < 3'd4) || (k == 3'd6);
        rd = rd_model(aa);
        exp_w = (sz == 3'd4) ? d : (sz == 3'd2) ? (d >> 16) : (d >> 24);
        if (st) exp_dep = d;
        else if (sz == 3'd4) exp_dep = rd;
        else if (sz == 3'd2) exp_dep = {rd[15:0], d[15:0]};
        else exp_dep = {rd[7:0], d[23:0]};

        @(negedge clk);
        start = 1'b1; store = st; key = k; req_cnt = rc; addr = a; dep_in = d;
        @(negedge clk);
        start = 1'b0;
        if (!ok) begin
            check("R5 kill", {31'b0, kill}, 32'd1);
            check("R5 no request", {31'b0, mem_req}, 32'd0);
            check("R5 dep kept", dep_out, d);
            @(negedge clk);
            check("R9 idle after kill", {30'b0, busy, kill}, 32'd0);
            return;
        end
        check("R6 request", {31'b0, mem_req}, 32'd1);
        check("R1 size", {29'b0, mem_size}, {29'b0, sz});
        check("R2 address", mem_addr, aa);
        check("R4 we", {31'b0, mem_we}, {31'b0, st});
        if (st) check("R4 wdata", mem_wdata, exp_w);
        for (int i = 0; i < dly; i++) begin
            if (extra_start) begin
                start = 1'b1; addr = a ^ 32'h0000_0F0F; dep_in = ~d; store = ~st;
            end
            @(negedge clk);
            start = 1'b0;
            check("R6 held", {31'b0, mem_req}, 32'd1);
            check("R6 addr held", mem_addr, aa);
            check(extra_start ? "R8 busy ignores start" : "R6 size held",
                  {29'b0, mem_size}, {29'b0, sz});
            if (st) check("R6 wdata held", mem_wdata, exp_w);
        end
        mem_ack = 1'b1;
        @(negedge clk);
        mem_ack = 1'b0;
        check("R7 done", {31'b0, done}, 32'd1);
        check(st ? "R4 dep unchanged" : "R3 load merge", dep_out, exp_dep);
        @(negedge clk);
        check("R7 done single", {30'b0, done, mem_req}, 32'd0);
    endtask

    initial begin
        rst_n = 1'b0; start = 1'b0; store = 1'b0; key = 3'd6; req_cnt = 3'd0;
        addr = '0; dep_in = '0; mem_ack = 1'b0;
        repeat (3) @(negedge clk);
        check("R9 reset", {28'b0, busy, done, kill, mem_req}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 idle", {28'b0, busy, done, kill, mem_req}, 32'd0);

        for (int s = 0; s < 2; s++)
            for (int r = 0; r < 8; r++)
                for (int o = 0; o < 4; o++)
                    run_op(s[0], 3'd6, r[2:0], 32'h4000_1230 + o + r * 32'h40,
                           32'hC3A5_9617 ^ (r * 32'h0101_0101) ^ (o << 12), (r + o) % 3, 1'b0);

        for (int k = 0; k < 8; k++) begin
            run_op(1'b0, k[2:0], 3'd2, 32'h0000_2003, 32'h1122_3344, 1, 1'b0);
            run_op(1'b1, k[2:0], 3'd1, 32'h0000_3001, 32'hA1B2_C3D4, 0, 1'b0);
        end

        run_op(1'b0, 3'd6, 3'd4, 32'h0000_5006, 32'h0BAD_F00D, 3, 1'b1);
        run_op(1'b1, 3'd0, 3'd3, 32'h0000_6007, 32'hFEDC_BA98, 2, 1'b1);

        finish_run();
    end
endmodule